// File: doc/BRIEF.md
# Multi-Core Level Interrupt Router

The block gathers 32 level-sensitive interrupt lines and fans them out to a grid of 16 request outputs, one for every combination of 4 processor cores and 4 priority lines per core. Each input owns a routing byte. The low nibble of that byte names the cores that may take the interrupt, and the high nibble names the priority lines it may raise. A global enable mask gates the inputs. Nothing is latched: an input counts as pending for exactly as long as its pin is high and its enable bit is set.

Software reaches the block through a single-cycle register request that carries an address, a byte/word size flag, a write enable and write data. Read data comes back one clock later. The registers are:
- the routing bytes;
- a word holding the masked pending set;
- the enable mask, with separate set and clear words;
- a read-only pending view for each core.

The outputs are registered. They follow the pins, the enable mask and the routing bytes with one cycle of delay.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every routing byte, the enable mask, `irq_o` and `rdata_o` are zero.
- R2: A word read at 0x20 returns the current pin levels ANDed with the enable mask. A bit clears as soon as its pin drops, so there is no latching.
- R3: Input i's routing byte is read and written with byte accesses at address i (0x00 to 0x1F). Read data carries it in bits 7:0, with bits 31:8 zero. Bits 3:0 select cores 0 to 3 and bits 7:4 select lines 0 to 3.
- R4: A word read at 0x24 returns the enable mask. A word write at 0x28 sets the mask bits wherever the write data has ones. A word write at 0x2C clears the mask bits wherever the write data has ones.
- R5: Core c's pending word is read at 0x40 + 8*c, and both aligned words of that 8-byte slot return it. Bit i of the word is set when input i is pending and bit c of its routing byte is set. Writes to this window change nothing.
- R6: `irq_o[4*c + l]` is high when core c's pending word is nonzero and at least one pending input has line bit l set. The two conditions are combined as a cross product, so they may come from different inputs.
- R7: `irq_o` reflects the state of the previous clock edge. A change on a pin or a register appears on `irq_o` exactly one cycle later.
- R8: The following accesses are ignored and read as zero: word accesses with address bits 1:0 nonzero, byte accesses at 0x20 or above, word accesses below 0x20, and word accesses to any unlisted offset (including 0x28, 0x2C on read, and 0x60 and above).
- R9: `rdata_o` holds the read result in the cycle after a read request. It is zero in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | 32 | Interrupt levels, already synchronous to clk_i |
| req_i | input | 1 | Register request valid for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 32-bit access, 0 = byte access |
| addr_i | input | 7 | Byte address of the access |
| wdata_i | input | 32 | Write data; byte writes use bits 7:0 |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 16 | Request grid, index 4*core + line |

## Verification
The bench targets the cross-product output rule. Two inputs are routed to disjoint core/line pairs, so a design that ANDs route bits within each input would raise only two outputs where four are expected. It drops pins while they are enabled and checks that the status word clears at once, which catches a design that latches. It also sends wrong-size, misaligned and unmapped accesses, plus writes to the per-core window, and checks that none of them disturbs the enable mask, the routing bytes or the read data. Finally, it counts the cycles from each pin or register change to `irq_o`, which exposes a missing or doubled output register.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned RT_W   = 8;

  localparam logic [ADDR_W-1:0] OFF_STAT  = 7'h20;
  localparam logic [ADDR_W-1:0] OFF_EN    = 7'h24;
  localparam logic [ADDR_W-1:0] OFF_SET   = 7'h28;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 7'h2C;
  localparam logic [ADDR_W-1:0] OFF_CORE  = 7'h40;
  localparam int unsigned       CORE_STEP = 8;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_ROUTE,
    ACC_STAT,
    ACC_EN,
    ACC_SET,
    ACC_CLR,
    ACC_CORE
  } acc_e;
endpackage

// File: rtl/irq_route_dec.sv
module irq_route_dec import irq_route_pkg::*; #(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned N_CORE = 4,
  localparam int unsigned CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1,
  localparam int unsigned IRQ_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic              req_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              kind_o,
  output logic [CORE_W-1:0] core_o,
  output logic [IRQ_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] CORE_END = ADDR_W'(int'(OFF_CORE) + CORE_STEP * N_CORE);
  localparam logic [ADDR_W-1:0] RT_END   = ADDR_W'(N_IRQ);

  logic [ADDR_W-1:0] core_off;

  assign core_off = addr_i - OFF_CORE;
  assign core_o   = CORE_W'(core_off >> $clog2(CORE_STEP));
  assign idx_o    = addr_i[IRQ_W-1:0];

  always_comb begin
    kind_o = ACC_NONE;
    if (req_i) begin
      if (!wide_i) begin
        if (addr_i < RT_END) kind_o = ACC_ROUTE;
      end else if (addr_i[1:0] == 2'b00) begin
        if (addr_i == OFF_STAT)      kind_o = ACC_STAT;
        else if (addr_i == OFF_EN)   kind_o = ACC_EN;
        else if (addr_i == OFF_SET)  kind_o = ACC_SET;
        else if (addr_i == OFF_CLR)  kind_o = ACC_CLR;
        else if (addr_i >= OFF_CORE && addr_i < CORE_END) kind_o = ACC_CORE;
      end
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs import irq_route_pkg::*; #(
  parameter int unsigned N_IRQ = 32,
  localparam int unsigned IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic                       wide_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  acc_e                       kind_i,
  input  logic [IRQ_W-1:0]           idx_i,
  output logic [N_IRQ-1:0][RT_W-1:0] route_o,
  output logic [N_IRQ-1:0]           en_o
);
  logic [N_IRQ-1:0][RT_W-1:0] route_q;
  logic [N_IRQ-1:0]           en_q;
  logic [N_IRQ-1:0]           wmask;

  assign wmask = wdata_i[N_IRQ-1:0];

  for (genvar g = 0; g < N_IRQ; g++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q[g] <= '0;
      else if (we_i && kind_i == ACC_ROUTE && idx_i == IRQ_W'(g)) route_q[g] <= wdata_i[RT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (we_i && kind_i == ACC_SET) en_q <= en_q | wmask;
    else if (we_i && kind_i == ACC_CLR) en_q <= en_q & ~wmask;
  end

  assign route_o = route_q;
  assign en_o    = en_q;

  // R4
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && wide_i && addr_i == OFF_SET) |=> ((en_q & $past(wmask)) == $past(wmask)));
  // R4
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && wide_i && addr_i == OFF_CLR) |=> ((en_q & $past(wmask)) == '0));
  // R8
  route_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wide_i) |=> $stable(route_q));
endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric import irq_route_pkg::*; #(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_LINE = 4
) (
  input  logic [N_IRQ-1:0]             lvl_i,
  input  logic [N_IRQ-1:0]             en_i,
  input  logic [N_IRQ-1:0][RT_W-1:0]   route_i,
  output logic [N_IRQ-1:0]             pend_o,
  output logic [N_CORE-1:0][N_IRQ-1:0] core_pend_o,
  output logic [N_CORE*N_LINE-1:0]     irq_d_o
);
  logic [N_LINE-1:0][N_IRQ-1:0] line_pend;

  assign pend_o = lvl_i & en_i;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    for (genvar c = 0; c < N_CORE; c++) begin : g_core
      assign core_pend_o[c][i] = pend_o[i] & route_i[i][c];
    end
    for (genvar l = 0; l < N_LINE; l++) begin : g_line
      assign line_pend[l][i] = pend_o[i] & route_i[i][N_CORE+l];
    end
  end

  // cross product: core condition and line condition may come from different inputs
  for (genvar c = 0; c < N_CORE; c++) begin : g_out_c
    for (genvar l = 0; l < N_LINE; l++) begin : g_out_l
      assign irq_d_o[c*N_LINE+l] = (|core_pend_o[c]) & (|line_pend[l]);
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl import irq_route_pkg::*; #(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_LINE = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_IRQ-1:0]         irq_lvl_i,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic                     wide_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [N_CORE*N_LINE-1:0] irq_o
);
  localparam int unsigned CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1;
  localparam int unsigned IRQ_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  acc_e                       kind;
  logic [CORE_W-1:0]          core_sel;
  logic [IRQ_W-1:0]           idx;
  logic [N_IRQ-1:0][RT_W-1:0] route_w;
  logic [N_IRQ-1:0]           en_w;
  logic [N_IRQ-1:0]           pend_w;
  logic [N_CORE-1:0][N_IRQ-1:0] core_pend_w;
  logic [N_CORE*N_LINE-1:0]   irq_d;
  logic [DATA_W-1:0]          rd_d;
  logic [DATA_W-1:0]          rd_q;
  logic [N_CORE*N_LINE-1:0]   irq_q;

  irq_route_dec #(.N_IRQ(N_IRQ), .N_CORE(N_CORE)) u_dec (
    .req_i  (req_i),
    .wide_i (wide_i),
    .addr_i (addr_i),
    .kind_o (kind),
    .core_o (core_sel),
    .idx_o  (idx)
  );

  irq_route_regs #(.N_IRQ(N_IRQ)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .wide_i  (wide_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .kind_i  (kind),
    .idx_i   (idx),
    .route_o (route_w),
    .en_o    (en_w)
  );

  irq_route_fabric #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_LINE(N_LINE)) u_fabric (
    .lvl_i       (irq_lvl_i),
    .en_i        (en_w),
    .route_i     (route_w),
    .pend_o      (pend_w),
    .core_pend_o (core_pend_w),
    .irq_d_o     (irq_d)
  );

  always_comb begin
    rd_d = '0;
    if (!we_i) begin
      unique case (kind)
        ACC_ROUTE: rd_d = DATA_W'(route_w[idx]);
        ACC_STAT:  rd_d = DATA_W'(pend_w);
        ACC_EN:    rd_d = DATA_W'(en_w);
        ACC_CORE:  rd_d = DATA_W'(core_pend_w[core_sel]);
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      irq_q <= '0;
    end else begin
      rd_q  <= rd_d;
      irq_q <= irq_d;
    end
  end

  assign rdata_o = rd_q;
  assign irq_o   = irq_q;

  // R6
  out_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(|pend_w));
  // R9
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> (rdata_o == '0));
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lvl = '0;
  logic        req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lvl_i(lvl), .req_i(req), .we_i(we),
    .wide_i(wide), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0]  m_route [32];
  logic [31:0] m_en;
  logic [15:0] exp_irq;
  logic [31:0] exp_rd;

  function automatic logic [15:0] m_out();
    logic [15:0] o = '0;
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < 4; l++) begin
        bit hc = 0, hl = 0;
        for (int i = 0; i < 32; i++)
          if (lvl[i] && m_en[i]) begin
            if (m_route[i][c]) hc = 1;
            if (m_route[i][4+l]) hl = 1;
          end
        o[c*4+l] = hc && hl;
      end
    return o;
  endfunction

  function automatic logic [31:0] m_read(logic w, logic [6:0] a);
    logic [31:0] r = '0;
    if (!w) begin
      if (a < 7'd32) r = {24'h0, m_route[a]};
    end else if (a[1:0] == 2'b00) begin
      if (a == 7'h20) r = lvl & m_en;
      else if (a == 7'h24) r = m_en;
      else if (a >= 7'h40 && a < 7'h60) begin
        int c = (int'(a) - 64) / 8;
        for (int i = 0; i < 32; i++) r[i] = lvl[i] & m_en[i] & m_route[i][c];
      end
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_route[i] = '0;
      m_en = '0; exp_irq = '0; exp_rd = '0;
    end else begin
      exp_irq = m_out();
      exp_rd  = (req && !we) ? m_read(wide, addr) : '0;
      if (req && we) begin
        if (!wide && addr < 7'd32) m_route[addr] = wdata[7:0];
        else if (wide && addr == 7'h28) m_en = m_en | wdata;
        else if (wide && addr == 7'h2C) m_en = m_en & ~wdata;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R6/R7 irq_o model", {16'h0, irq}, {16'h0, exp_irq});
    chk("R9 rdata_o model", rdata, exp_rd);
  end

  task automatic wr(logic w, logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; wide = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic w, logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; wide = w; addr = a;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R1 irq_o in reset", {16'h0, irq}, 32'h0);
    chk("R1 rdata_o in reset", rdata, 32'h0);
    rst_n = 1;
    lvl = 32'h0000_0088;
    rd(0, 7'd3, v);   chk("R1 route after reset", v, 32'h0);
    rd(1, 7'h24, v);  chk("R1 enable after reset", v, 32'h0);
    rd(1, 7'h20, v);  chk("R2 status gated by enable", v, 32'h0);

    wr(0, 7'd3, 32'hFFFF_FF11);
    wr(0, 7'd7, 32'h0000_0022);
    rd(0, 7'd3, v);   chk("R3 route byte readback", v, 32'h11);
    lvl = 32'h0000_0008;
    wr(1, 7'h28, 32'h0000_0088);
    rd(1, 7'h24, v);  chk("R4 enable set", v, 32'h88);
    chk("R6 single route", {16'h0, irq}, 32'h0001);
    // R7: pin change seen one cycle later
    lvl = 32'h0000_0088;
    chk("R7 before edge", {16'h0, irq}, 32'h0001);
    @(negedge clk);
    chk("R6 cross product", {16'h0, irq}, 32'h0033);
    rd(1, 7'h20, v);  chk("R2 status", v, 32'h88);
    rd(1, 7'h40, v);  chk("R5 core0 word", v, 32'h08);
    rd(1, 7'h44, v);  chk("R5 second word of slot", v, 32'h08);
    rd(1, 7'h48, v);  chk("R5 core1 word", v, 32'h80);
    wr(1, 7'h48, 32'hFFFF_FFFF);
    rd(1, 7'h48, v);  chk("R5 write ignored", v, 32'h80);
    lvl = 32'h0000_0080;
    rd(1, 7'h20, v);  chk("R2 no latching", v, 32'h80);
    lvl = 32'h0000_0088;
    wr(1, 7'h2C, 32'h0000_0080);
    rd(1, 7'h24, v);  chk("R4 enable clear", v, 32'h08);
    chk("R6 after clear", {16'h0, irq}, 32'h0001);

    wr(0, 7'h24, 32'hFF);
    wr(1, 7'h29, 32'hFFFF_FFFF);
    wr(1, 7'h04, 32'hFFFF_FFFF);
    wr(1, 7'h00, 32'hFFFF_FFFF);
    rd(1, 7'h24, v);  chk("R8 enable untouched", v, 32'h08);
    rd(0, 7'd1, v);   chk("R8 route untouched", v, 32'h0);
    rd(0, 7'd3, v);   chk("R8 route 3 untouched", v, 32'h11);
    rd(0, 7'h20, v);  chk("R8 byte read of status", v, 32'h0);
    rd(1, 7'h28, v);  chk("R8 read of set word", v, 32'h0);
    rd(1, 7'h60, v);  chk("R8 past core window", v, 32'h0);
    rd(1, 7'h00, v);  chk("R8 word read of route", v, 32'h0);
    rd(1, 7'h22, v);  chk("R8 misaligned read", v, 32'h0);
    @(negedge clk);
    chk("R9 idle rdata", rdata, 32'h0);

    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      lvl   = $urandom;
      req   = ($urandom % 3) != 0;
      we    = $urandom % 2;
      wide  = $urandom % 2;
      addr  = 7'($urandom);
      wdata = $urandom;
    end
    @(negedge clk);
    req = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule